// File: doc/BRIEF.md
# Boundary-Scan Register for Grouped Bidirectional Pins

This block is the boundary-scan data register that sits between a chip's core and a bank of bidirectional pins. The pins are split into groups. Each group shares one output-enable scan cell, and every pin has its own data scan cell. Each cell has a shift stage, loaded in parallel on capture and chained serially on shift, and an update stage that is loaded from the shift stage on the falling test clock.

A TAP controller and an instruction decoder outside the block supply a register-select strobe, the capture/shift/update controls and a mode bit. The mode bit chooses external test or sample/preload.

In sample/preload the pins run normally. In external test the update stages drive the pin values and pin enables, while the levels at the pins still reach the core.

The chain has a fixed layout. With `NP = NGRP*PPG` pins, pin k sits at chain bit k. Group g's output-enable cell sits at bit `NP+g`, and group g owns pins `g*PPG` through `g*PPG+PPG-1`. `tdi` enters at the top bit and `tdo` is bit 0. With the defaults (4 groups of 10 pins), the enable cells are bits 43 down to 40.

Top module: `bsr_bidir_chain`

## Requirements
- R1: With `mode_extest`=0, `pin_out` equals `core_out`, `pin_oe` equals `core_oe`, and `core_in` equals `pin_in`, in the same cycle.
- R2: With `mode_extest`=1, `pin_oe[g]` equals the update stage at chain bit NP+g, and `pin_out[k]` equals the update stage at chain bit k.
- R3: In both modes, `core_in` follows `pin_in` combinationally.
- R4: On a rising `tck` with `sel`=1, `capture_dr`=1 and `mode_extest`=1, pin cell k loads `pin_in[k]` and enable cell g loads `core_oe[g]`.
- R5: On a capture edge with `mode_extest`=0, pin cell k loads `core_out[k]` if `core_oe` of its group is 1, and loads `pin_in[k]` otherwise. Enable cells load `core_oe`.
- R6: On a rising `tck` with `sel`=1, `shift_dr`=1 and `capture_dr`=0, every shift stage takes the value of the bit above it, and bit L-1 takes `tdi`. `tdo` always shows bit 0.
- R7: On a falling `tck` with `sel`=1 and `update_dr`=1, every update stage copies its shift stage. Otherwise the update stages hold.
- R8: While `sel`=0, the capture, shift and update controls have no effect. The shift stages and update stages hold, which is visible later through `tdo` and the pin outputs in external test.
- R9: `trst_n` low clears every shift stage and update stage asynchronously. The clear is released on the second rising `tck` after `trst_n` rises. While the enable stages are 0, external test leaves all of `pin_oe` at 0.
- R10: When `capture_dr` and `shift_dr` are both 1 on the same edge, capture takes effect and shift does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| sel | input | 1 | This register is the selected scan target |
| capture_dr | input | 1 | Parallel-load the shift stages on the rising edge |
| shift_dr | input | 1 | Shift the chain one bit toward `tdo` on the rising edge |
| update_dr | input | 1 | Copy the shift stages to the update stages on the falling edge |
| mode_extest | input | 1 | 1 = external test, 0 = sample/preload |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (chain bit 0) |
| core_out | input | NGRP*PPG | Core output data for each pin |
| core_oe | input | NGRP | Core output enable for each group |
| pin_in | input | NGRP*PPG | Level sensed at each pin |
| pin_out | output | NGRP*PPG | Value driven onto each pin |
| pin_oe | output | NGRP | Drive enable for each group |
| core_in | output | NGRP*PPG | Pin data passed to the core |

## Verification
A behavioural model in the bench is compared against every output on every clock while the stimulus moves through several phases:
- Plain mission traffic with random, all-zero and all-one enables shows that pass-through holds regardless of what the scan stages contain.
- Sample captures with mixed group enables, shifted out in full, show whether each pin picks its source according to its own group's direction and not some other group's.
- Preloads with random patterns and with deliberate enable patterns, followed by external test, separate a wrong group-to-pin mapping from a wrong update edge.
- Deselected control activity, a simultaneous capture and shift, and a mid-run reset probe the hold, priority and clear rules.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic {
    MODE_SAMPLE = 1'b0,
    MODE_EXTEST = 1'b1
  } bsr_mode_e;

  // total chain length: one cell per pin plus one enable cell per group
  function automatic int chain_len(input int ngrp, input int ppg);
    return ngrp * ppg + ngrp;
  endfunction

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic q1, q2;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q1 <= 1'b0;
      q2 <= 1'b0;
    end else begin
      q1 <= 1'b1;
      q2 <= q1;
    end
  end

  assign rst_n_sync = q2;

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic ser_in,
  output logic sr_q,
  output logic upd_q
);

  logic sr_d;
  logic upd_d;

  // capture has priority over shift
  always_comb begin
    sr_d = sr_q;
    if (cap_en) begin
      sr_d = cap_d;
    end else if (shift_en) begin
      sr_d = ser_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
    end
  end

  always_comb begin
    upd_d = upd_q;
    if (upd_en) begin
      upd_d = sr_q;
    end
  end

  // update stage is clocked on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

endmodule

// File: rtl/bsr_group.sv
module bsr_group #(
  parameter int PPG = 10
) (
  input  logic           mode_extest,
  input  logic           core_oe_g,
  input  logic           upd_oe_g,
  input  logic [PPG-1:0] core_out_g,
  input  logic [PPG-1:0] pin_in_g,
  input  logic [PPG-1:0] upd_pin_g,
  output logic           pin_oe_g,
  output logic [PPG-1:0] pin_out_g,
  output logic [PPG-1:0] core_in_g,
  output logic [PPG-1:0] cap_d_g
);

  import bsr_pkg::*;

  bsr_mode_e mode;

  always_comb begin
    mode = bsr_mode_e'(mode_extest);
    for (int i = 0; i < PPG; i++) begin
      if (mode == MODE_EXTEST) begin
        cap_d_g[i] = pin_in_g[i];
      end else begin
        // sample: source depends on the group's present direction
        cap_d_g[i] = core_oe_g ? core_out_g[i] : pin_in_g[i];
      end
    end
    if (mode == MODE_EXTEST) begin
      pin_oe_g  = upd_oe_g;
      pin_out_g = upd_pin_g;
    end else begin
      pin_oe_g  = core_oe_g;
      pin_out_g = core_out_g;
    end
    core_in_g = pin_in_g;
  end

endmodule

// File: rtl/bsr_bidir_chain.sv
module bsr_bidir_chain #(
  parameter int NGRP = 4,
  parameter int PPG  = 10
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 sel,
  input  logic                 capture_dr,
  input  logic                 shift_dr,
  input  logic                 update_dr,
  input  logic                 mode_extest,
  input  logic                 tdi,
  output logic                 tdo,
  input  logic [NGRP*PPG-1:0]  core_out,
  input  logic [NGRP-1:0]      core_oe,
  input  logic [NGRP*PPG-1:0]  pin_in,
  output logic [NGRP*PPG-1:0]  pin_out,
  output logic [NGRP-1:0]      pin_oe,
  output logic [NGRP*PPG-1:0]  core_in
);

  localparam int NP = NGRP * PPG;
  localparam int L  = bsr_pkg::chain_len(NGRP, PPG);

  logic         rst_s;
  logic         cap_en, shift_en, upd_en;
  logic [L-1:0] sr_q;
  logic [L-1:0] up_q;
  logic [L-1:0] cap_d;
  logic [L-1:0] ser_in;
  logic [NP-1:0] oe_mask;

  bsr_rst_sync u_rst (
    .clk        (tck),
    .arst_n     (trst_n),
    .rst_n_sync (rst_s)
  );

  assign cap_en   = sel & capture_dr;
  assign shift_en = sel & shift_dr;
  assign upd_en   = sel & update_dr;

  // serial path runs from the top bit down to bit 0
  assign ser_in = {tdi, sr_q[L-1:1]};
  assign tdo    = sr_q[0];

  assign cap_d[L-1:NP] = core_oe;

  for (genvar k = 0; k < L; k++) begin : g_cell
    bsr_cell u_cell (
      .clk      (tck),
      .rst_n    (rst_s),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .upd_en   (upd_en),
      .cap_d    (cap_d[k]),
      .ser_in   (ser_in[k]),
      .sr_q     (sr_q[k]),
      .upd_q    (up_q[k])
    );
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    bsr_group #(.PPG(PPG)) u_grp (
      .mode_extest (mode_extest),
      .core_oe_g   (core_oe[g]),
      .upd_oe_g    (up_q[NP+g]),
      .core_out_g  (core_out[g*PPG +: PPG]),
      .pin_in_g    (pin_in[g*PPG +: PPG]),
      .upd_pin_g   (up_q[g*PPG +: PPG]),
      .pin_oe_g    (pin_oe[g]),
      .pin_out_g   (pin_out[g*PPG +: PPG]),
      .core_in_g   (core_in[g*PPG +: PPG]),
      .cap_d_g     (cap_d[g*PPG +: PPG])
    );
    assign oe_mask[g*PPG +: PPG] = {PPG{core_oe[g]}};
  end

  // R8: deselected register keeps its shift stages
  assert_hold_when_idle_R8: assert property (@(posedge tck) disable iff (!rst_s)
    !sel |=> $stable(sr_q));

  // R6: one-bit shift reaches tdo
  assert_shift_to_tdo_R6: assert property (@(posedge tck) disable iff (!rst_s)
    (sel && shift_dr && !capture_dr) |=> (tdo == $past(sr_q[1])));

  // R5: sample capture follows each group's direction
  assert_sample_capture_R5: assert property (@(posedge tck) disable iff (!rst_s)
    (sel && capture_dr && !mode_extest) |=>
      (sr_q[NP-1:0] == (($past(core_out) & $past(oe_mask)) |
                        ($past(pin_in) & ~$past(oe_mask)))));

  // R4: external-test capture takes pin levels and core enables
  assert_extest_capture_R4: assert property (@(posedge tck) disable iff (!rst_s)
    (sel && capture_dr && mode_extest) |=>
      (sr_q == {$past(core_oe), $past(pin_in)}));

  // R9: enable update stages are clear when reset releases
  assert_oe_clear_on_reset_R9: assert property (@(posedge tck) disable iff (!rst_s)
    $rose(rst_s) |-> (up_q[L-1:NP] == '0));

endmodule

// File: tb/test_bsr_bidir_chain.sv
module test_bsr_bidir_chain;

  localparam int NGRP = 4;
  localparam int PPG  = 10;
  localparam int NP   = NGRP * PPG;
  localparam int L    = NP + NGRP;

  logic tck = 1'b0;
  logic trst_n = 1'b1;
  logic sel = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, mode_extest = 0, tdi = 0;
  logic tdo;
  logic [NP-1:0]   core_out = '0, pin_in = '0;
  logic [NGRP-1:0] core_oe = '0;
  logic [NP-1:0]   pin_out, core_in;
  logic [NGRP-1:0] pin_oe;

  always #2 tck = ~tck;

  bsr_bidir_chain #(.NGRP(NGRP), .PPG(PPG)) i_bsr_bidir_chain (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .mode_extest(mode_extest),
    .tdi(tdi), .tdo(tdo), .core_out(core_out), .core_oe(core_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in)
  );

  int m_sr[L];
  int m_up[L];
  bit s1, s2;
  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R9";

  function automatic int capval(int k);
    if (k >= NP) return int'(core_oe[k-NP]);
    if (mode_extest) return int'(pin_in[k]);
    return core_oe[k/PPG] ? int'(core_out[k]) : int'(pin_in[k]);
  endfunction

  // reference model: rising edge
  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      s1 = 0; s2 = 0;
      for (int k = 0; k < L; k++) begin m_sr[k] = 0; m_up[k] = 0; end
    end else begin
      if (s2 && sel) begin
        if (capture_dr) begin
          for (int k = 0; k < L; k++) m_sr[k] = capval(k);
        end else if (shift_dr) begin
          for (int k = 0; k < L-1; k++) m_sr[k] = m_sr[k+1];
          m_sr[L-1] = int'(tdi);
        end
      end
      s2 = s1;
      s1 = 1;
    end
  end

  // reference model: falling edge
  always @(negedge tck) begin
    if (trst_n && s2 && sel && update_dr)
      for (int k = 0; k < L; k++) m_up[k] = m_sr[k];
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from both edges
  always @(negedge tck) begin
    logic [NP-1:0]   e_out;
    logic [NGRP-1:0] e_oe;
    string t_pin, t_cin;
    #1;
    for (int k = 0; k < NP; k++) e_out[k] = mode_extest ? m_up[k][0] : core_out[k];
    for (int g = 0; g < NGRP; g++) e_oe[g] = mode_extest ? m_up[NP+g][0] : core_oe[g];
    t_pin = (cur_tag == "R9") ? "R9" : (mode_extest ? "R2" : "R1");
    t_cin = (cur_tag == "R9") ? "R9" : (mode_extest ? "R3" : "R1");
    chk(cur_tag, "tdo", 64'(tdo), 64'(m_sr[0][0]));
    chk(t_pin, "pin_out", 64'(pin_out), 64'(e_out));
    chk(t_pin, "pin_oe", 64'(pin_oe), 64'(e_oe));
    chk(t_cin, "core_in", 64'(core_in), 64'(pin_in));
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge tck); #1; end
  endtask

  function automatic logic [NP-1:0] rnd_np();
    return NP'({$urandom, $urandom});
  endfunction

  task automatic shift_all(int oe_pat, bit use_pat);
    shift_dr = 1;
    for (int k = 0; k < L; k++) begin
      if (use_pat && k >= NP) tdi = oe_pat[k-NP];
      else tdi = $urandom_range(0, 1);
      cyc(1);
    end
    shift_dr = 0;
  endtask

  task automatic do_update();
    update_dr = 1; cyc(1); update_dr = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #1 trst_n = 0;
    cyc(3);
    trst_n = 1;
    cyc(4);

    // R1: mission traffic
    cur_tag = "R1";
    core_oe = '0; core_out = rnd_np(); pin_in = rnd_np(); cyc(2);
    core_oe = '1; core_out = rnd_np(); pin_in = rnd_np(); cyc(2);
    repeat (4) begin
      core_oe = NGRP'($urandom); core_out = rnd_np(); pin_in = rnd_np(); cyc(1);
    end

    // R5: sample capture with mixed directions, then shift out
    cur_tag = "R5";
    sel = 1; core_oe = 4'b0101; core_out = rnd_np(); pin_in = rnd_np();
    capture_dr = 1; cyc(1); capture_dr = 0;
    shift_all(0, 0);
    core_oe = 4'b1010; core_out = rnd_np(); pin_in = rnd_np();
    capture_dr = 1; cyc(1); capture_dr = 0;
    shift_all(0, 0);

    // R6/R7: preload and update, then external test
    cur_tag = "R6";
    shift_all(4'b0110, 1);
    cur_tag = "R7";
    do_update(); cyc(1);
    mode_extest = 1;
    cur_tag = "R2";
    repeat (4) begin pin_in = rnd_np(); core_out = rnd_np(); cyc(1); end
    cur_tag = "R6";
    shift_all(4'b1001, 1);
    cur_tag = "R7";
    do_update();
    repeat (3) begin pin_in = rnd_np(); cyc(1); end

    // R4: external-test capture
    cur_tag = "R4";
    pin_in = rnd_np(); core_oe = 4'b0011;
    capture_dr = 1; cyc(1); capture_dr = 0;
    shift_all(0, 0);

    // R10: capture and shift together
    cur_tag = "R10";
    pin_in = rnd_np(); core_oe = 4'b1100; tdi = 1;
    capture_dr = 1; shift_dr = 1; cyc(1); capture_dr = 0; shift_dr = 0;
    shift_all(0, 0);

    // R8: deselected controls ignored
    cur_tag = "R8";
    shift_all(4'b1111, 1);
    sel = 0;
    repeat (6) begin
      capture_dr = $urandom_range(0, 1); shift_dr = $urandom_range(0, 1);
      update_dr = $urandom_range(0, 1); tdi = $urandom_range(0, 1);
      pin_in = rnd_np(); core_oe = NGRP'($urandom); cyc(1);
    end
    capture_dr = 0; shift_dr = 0; update_dr = 0;
    sel = 1;
    shift_all(0, 0);

    // R9: reset in the middle of external test
    cur_tag = "R7";
    shift_all(4'b1111, 1);
    do_update(); cyc(1);
    cur_tag = "R9";
    trst_n = 0; cyc(2);
    trst_n = 1; cyc(4);
    cur_tag = "R2";
    pin_in = rnd_np(); cyc(2);

    finish_run();
  end

endmodule